// File: doc/BRIEF.md
# Synthesizer Power and Retune Sequencer

This controller decides whether the IF and RF synthesizer sections of a frequency-synthesis subsystem are powered. It combines a board-level run pin, two per-section power bits and a force-on configuration bit. Each time a section comes up, or a new divider value is written to a section that is already running, the controller steps that section through a self-tune window and then a settle window. Both windows are timed in half update periods of the phase detector, so a window of 6.5 update periods can be counted exactly.

The two RF oscillators share one output. A route bit records which RF divider register was written most recently, and that oscillator drives the shared output. An auxiliary output is chosen by a 2-bit select. One code shows an active-high "not locked" status. That status is raised while either section is tuning, or while an enabled section reports that it is close to the edge of its correction range. Every other code holds the pin low.

The analog tuning loop sits outside this block. The block supplies the enables and the tune window, and it reports the phase each section is in.

Top module: `pwr_tune_seq`

## Requirements
- R1: While `hw_run` is 0, `if_en`, `rf_en` and `ref_en` are 0 whatever the configuration bits hold, and after reset every output is 0.
- R2: While `hw_run` is 1, `if_en` equals `if_pwr_bit` and `rf_en` equals `rf_pwr_bit`, where 1 means powered, unless R3 applies.
- R3: While `hw_run` is 1 and `auto_on` is 1, both `if_en` and `rf_en` are 1 whatever the two power bits hold.
- R4: `ref_en` is 1 exactly when `if_en` or `rf_en` is 1.
- R5: A section starts a tune sequence at the clock edge where its enable is first seen high, or where a divider write for it (`n_wr_if` for IF, `n_wr_rf_a` or `n_wr_rf_b` for RF) is seen while it is enabled. `tune_active` is 1 in the cycle that follows that edge.
- R6: A section's tune window ends at the edge that samples the 13th `half_tick` after its start. `tune_active` is the OR of the two sections' windows.
- R7: `ready_if` or `ready_rf` rises at the edge that samples the 56th `half_tick` after that section's start. Both are cleared at the first edge where the section is disabled.
- R8: A start that arrives during a section's tune or settle window restarts that section's half-tick count from zero. A `half_tick` seen at the same edge as a start is not counted.
- R9: With `aux_sel` = 2'b11, `aux_out` is 1 while `tune_active` is 1, or while `near_lim_if` is 1 with `if_en` 1, or while `near_lim_rf` is 1 with `rf_en` 1. Otherwise it is 0.
- R10: With `aux_sel` equal to 2'b00, 2'b01 or 2'b10, `aux_out` is 0.
- R11: `rf_sel` is 0 after reset. It becomes 0 after a write to `n_wr_rf_a` and 1 after a write to `n_wr_rf_b`, and `n_wr_rf_b` wins if both are seen at the same edge. Writes made while RF is off still move `rf_sel` but start no tune.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_run | input | 1 | Board run pin; 0 forces both sections off |
| auto_on | input | 1 | Force-on configuration bit |
| if_pwr_bit | input | 1 | IF section power bit (1 = on) |
| rf_pwr_bit | input | 1 | RF section power bit (1 = on) |
| aux_sel | input | 2 | Auxiliary output select |
| n_wr_if | input | 1 | One-cycle strobe: IF divider written |
| n_wr_rf_a | input | 1 | One-cycle strobe: first RF divider written |
| n_wr_rf_b | input | 1 | One-cycle strobe: second RF divider written |
| half_tick | input | 1 | One-cycle pulse every half update period |
| near_lim_if | input | 1 | IF loop near the edge of its correction range |
| near_lim_rf | input | 1 | RF loop near the edge of its correction range |
| if_en | output | 1 | IF section enable |
| rf_en | output | 1 | RF section enable |
| ref_en | output | 1 | Reference amplifier enable |
| tune_active | output | 1 | Either section is in its self-tune window |
| ready_if | output | 1 | IF section settled |
| ready_rf | output | 1 | RF section settled |
| rf_sel | output | 1 | Shared RF output source (0 = first, 1 = second) |
| aux_out | output | 1 | Auxiliary output |

## Verification
The hardest case to reach is a retune that lands inside a window already running. This happens when a divider write arrives partway through one section's tune or settle count, while the other section is in a different phase. The directed part of the stimulus handles this. It counts out exact runs of `half_tick` pulses, injects a write after ten of them, and then counts again across the 13 and 56 boundaries. A long random phase follows, with power bits that change rarely, sparse writes and dense ticks. In that phase restarts overlap across both sections, and a behavioural model checks every cycle.

// File: rtl/pwr_tune_seq_pkg.sv
package pwr_tune_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF    = 2'd0,
        SEQ_TUNE   = 2'd1,
        SEQ_SETTLE = 2'd2,
        SEQ_READY  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic if_on;
        logic rf_on;
    } sect_en_t;

    typedef struct packed {
        logic tuning;
        logic ready;
    } chan_stat_t;

    localparam int NUM_CHAN  = 2;
    localparam int CH_IF     = 0;
    localparam int CH_RF     = 1;
    localparam logic [1:0] AUX_LOCK_CODE = 2'b11;

    function automatic sect_en_t decide_power(
        input logic run_pin,
        input logic force_on,
        input logic if_bit,
        input logic rf_bit
    );
        sect_en_t r;
        r.if_on = run_pin & (force_on | if_bit);
        r.rf_on = run_pin & (force_on | rf_bit);
        return r;
    endfunction

endpackage

// File: rtl/pts_power_gate.sv
module pts_power_gate
    import pwr_tune_seq_pkg::*;
(
    input  logic     run_pin,
    input  logic     force_on,
    input  logic     if_bit,
    input  logic     rf_bit,
    output sect_en_t sect_en,
    output logic     ref_on
);
    always_comb begin
        sect_en = decide_power(run_pin, force_on, if_bit, rf_bit);
        ref_on  = sect_en.if_on | sect_en.rf_on;
    end
endmodule

// File: rtl/pts_chan_seq.sv
module pts_chan_seq
    import pwr_tune_seq_pkg::*;
#(
    parameter int TUNE_HALVES  = 13,
    parameter int TOTAL_HALVES = 56
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       retune,
    input  logic       half_tick,
    output chan_stat_t stat
);
    localparam int CW = $clog2(TOTAL_HALVES + 1);
    localparam logic [CW-1:0] TUNE_LAST  = CW'(TUNE_HALVES - 1);
    localparam logic [CW-1:0] TOTAL_LAST = CW'(TOTAL_HALVES - 1);

    seq_state_e    st;
    logic [CW-1:0] cnt;
    logic          en_q;
    logic          start;
    logic          counting;

    assign start    = en & (~en_q | retune);
    assign counting = (st == SEQ_TUNE) || (st == SEQ_SETTLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SEQ_OFF;
            cnt  <= '0;
            en_q <= 1'b0;
        end else begin
            en_q <= en;
            if (!en) begin
                st  <= SEQ_OFF;
                cnt <= '0;
            end else if (start) begin
                st  <= SEQ_TUNE;
                cnt <= '0;
            end else if (half_tick && counting) begin
                cnt <= cnt + 1'b1;
                if (st == SEQ_TUNE && cnt == TUNE_LAST) begin
                    st <= SEQ_SETTLE;
                end else if (st == SEQ_SETTLE && cnt == TOTAL_LAST) begin
                    st <= SEQ_READY;
                end
            end
        end
    end

    always_comb begin
        stat.tuning = (st == SEQ_TUNE);
        stat.ready  = (st == SEQ_READY);
    end
endmodule

// File: rtl/pts_rf_route.sv
module pts_rf_route (
    input  logic clk,
    input  logic rst,
    input  logic wr_a,
    input  logic wr_b,
    output logic sel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= 1'b0;
        end else if (wr_b) begin
            sel <= 1'b1;
        end else if (wr_a) begin
            sel <= 1'b0;
        end
    end
endmodule

// File: rtl/pts_aux_mux.sv
module pts_aux_mux
    import pwr_tune_seq_pkg::*;
(
    input  logic [1:0] code,
    input  logic       not_locked,
    output logic       pin
);
    always_comb begin
        case (code)
            AUX_LOCK_CODE: pin = not_locked;
            default:       pin = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwr_tune_seq.sv
module pwr_tune_seq
    import pwr_tune_seq_pkg::*;
#(
    parameter int TUNE_HALVES  = 13,
    parameter int TOTAL_HALVES = 56
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hw_run,
    input  logic       auto_on,
    input  logic       if_pwr_bit,
    input  logic       rf_pwr_bit,
    input  logic [1:0] aux_sel,
    input  logic       n_wr_if,
    input  logic       n_wr_rf_a,
    input  logic       n_wr_rf_b,
    input  logic       half_tick,
    input  logic       near_lim_if,
    input  logic       near_lim_rf,
    output logic       if_en,
    output logic       rf_en,
    output logic       ref_en,
    output logic       tune_active,
    output logic       ready_if,
    output logic       ready_rf,
    output logic       rf_sel,
    output logic       aux_out
);
    sect_en_t             sect;
    logic [NUM_CHAN-1:0]  ch_en;
    logic [NUM_CHAN-1:0]  ch_wr;
    logic [NUM_CHAN-1:0]  ch_near;
    chan_stat_t           ch_stat [NUM_CHAN];
    logic [NUM_CHAN-1:0]  ch_tune;
    logic                 not_locked;

    pts_power_gate u_gate (
        .run_pin  (hw_run),
        .force_on (auto_on),
        .if_bit   (if_pwr_bit),
        .rf_bit   (rf_pwr_bit),
        .sect_en  (sect),
        .ref_on   (ref_en)
    );

    assign ch_en[CH_IF]   = sect.if_on;
    assign ch_en[CH_RF]   = sect.rf_on;
    assign ch_wr[CH_IF]   = n_wr_if;
    assign ch_wr[CH_RF]   = n_wr_rf_a | n_wr_rf_b;
    assign ch_near[CH_IF] = near_lim_if;
    assign ch_near[CH_RF] = near_lim_rf;

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        pts_chan_seq #(
            .TUNE_HALVES  (TUNE_HALVES),
            .TOTAL_HALVES (TOTAL_HALVES)
        ) u_seq (
            .clk       (clk),
            .rst       (rst),
            .en        (ch_en[c]),
            .retune    (ch_wr[c]),
            .half_tick (half_tick),
            .stat      (ch_stat[c])
        );
        assign ch_tune[c] = ch_stat[c].tuning;
    end

    pts_rf_route u_route (
        .clk  (clk),
        .rst  (rst),
        .wr_a (n_wr_rf_a),
        .wr_b (n_wr_rf_b),
        .sel  (rf_sel)
    );

    assign not_locked = (|ch_tune) | (|(ch_near & ch_en));

    pts_aux_mux u_aux (
        .code       (aux_sel),
        .not_locked (not_locked),
        .pin        (aux_out)
    );

    assign if_en       = sect.if_on;
    assign rf_en       = sect.rf_on;
    assign tune_active = |ch_tune;
    assign ready_if    = ch_stat[CH_IF].ready;
    assign ready_rf    = ch_stat[CH_RF].ready;
endmodule

// File: rtl/pwr_tune_seq_chk.sv
module pwr_tune_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       hw_run,
    input logic       auto_on,
    input logic [1:0] aux_sel,
    input logic       n_wr_rf_a,
    input logic       n_wr_rf_b,
    input logic       if_en,
    input logic       rf_en,
    input logic       ref_en,
    input logic       tune_active,
    input logic       ready_if,
    input logic       ready_rf,
    input logic       rf_sel,
    input logic       aux_out
);
    AST_PIN_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
        !hw_run |-> (!if_en && !rf_en && !ref_en)); // R1
    AST_AUTO_BOTH_ON: assert property (@(posedge clk) disable iff (rst)
        (hw_run && auto_on) |-> (if_en && rf_en)); // R3
    AST_REF_WITH_SECTION: assert property (@(posedge clk) disable iff (rst)
        (if_en || rf_en) |-> ref_en); // R4
    AST_IF_RISE_TUNES: assert property (@(posedge clk) disable iff (rst)
        $rose(if_en) |=> (tune_active || !if_en)); // R5
    AST_RF_RISE_TUNES: assert property (@(posedge clk) disable iff (rst)
        $rose(rf_en) |=> (tune_active || !rf_en)); // R5
    AST_IF_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !if_en |=> !ready_if); // R7
    AST_RF_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !rf_en |=> !ready_rf); // R7
    AST_TUNE_FLAGS_AUX: assert property (@(posedge clk) disable iff (rst)
        (tune_active && aux_sel == 2'b11) |-> aux_out); // R9
    AST_AUX_QUIET: assert property (@(posedge clk) disable iff (rst)
        (aux_sel != 2'b11) |-> !aux_out); // R10
    AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!n_wr_rf_a && !n_wr_rf_b) |=> $stable(rf_sel)); // R11
endmodule

bind pwr_tune_seq pwr_tune_seq_chk chk_i (.*);

// File: tb/pwr_tune_seq_tb_top.sv
module pwr_tune_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hw_run = 0, auto_on = 0, if_pwr_bit = 0, rf_pwr_bit = 0;
    logic [1:0] aux_sel = 2'b00;
    logic       n_wr_if = 0, n_wr_rf_a = 0, n_wr_rf_b = 0, half_tick = 0;
    logic       near_lim_if = 0, near_lim_rf = 0;
    logic       if_en, rf_en, ref_en, tune_active, ready_if, ready_rf, rf_sel, aux_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pwr_tune_seq dut_i (.*);

    // Behavioural reference: half ticks since start per section, -1 when off
    int  m_h [2];
    bit  m_enq [2];
    bit  m_sel;

    function automatic bit exp_if_en();  return hw_run & (auto_on | if_pwr_bit); endfunction
    function automatic bit exp_rf_en();  return hw_run & (auto_on | rf_pwr_bit); endfunction
    function automatic bit exp_tune();
        return (m_h[0] >= 0 && m_h[0] < 13) || (m_h[1] >= 0 && m_h[1] < 13);
    endfunction
    function automatic bit exp_aux();
        bit lk;
        lk = exp_tune() | (near_lim_if & exp_if_en()) | (near_lim_rf & exp_rf_en());
        return (aux_sel == 2'b11) ? lk : 1'b0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_h[0] = -1; m_h[1] = -1; m_enq[0] = 0; m_enq[1] = 0; m_sel = 0;
        end else begin
            bit en [2];
            bit wr [2];
            en[0] = exp_if_en(); en[1] = exp_rf_en();
            wr[0] = n_wr_if;     wr[1] = n_wr_rf_a | n_wr_rf_b;
            for (int c = 0; c < 2; c++) begin
                if (!en[c]) m_h[c] = -1;
                else if (!m_enq[c] || wr[c]) m_h[c] = 0;
                else if (half_tick && m_h[c] >= 0 && m_h[c] < 56) m_h[c] = m_h[c] + 1;
                m_enq[c] = en[c];
            end
            if (n_wr_rf_b) m_sel = 1;
            else if (n_wr_rf_a) m_sel = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            chk("R2 if_en", if_en, exp_if_en());
            chk("R2 rf_en", rf_en, exp_rf_en());
            chk("R4 ref_en", ref_en, exp_if_en() | exp_rf_en());
            chk("R6 tune_active", tune_active, exp_tune());
            chk("R7 ready_if", ready_if, m_h[0] == 56);
            chk("R7 ready_rf", ready_rf, m_h[1] == 56);
            chk("R11 rf_sel", rf_sel, m_sel);
            chk("R9 aux_out", aux_out, exp_aux());
        end
    end

    task automatic cyc(); @(negedge clk); endtask
    task automatic pulse_half(); half_tick = 1; cyc(); half_tick = 0; cyc(); endtask
    task automatic halves(input int n); for (int i = 0; i < n; i++) pulse_half(); endtask
    task automatic settle_look(); #2; endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) cyc();
        settle_look();
        chk("R1 reset outputs", {if_en, rf_en, ref_en, tune_active, ready_if, ready_rf, rf_sel, aux_out}, 0);
        cyc(); rst = 0;

        // R1: pin low overrides every bit
        if_pwr_bit = 1; rf_pwr_bit = 1; auto_on = 1; settle_look();
        chk("R1 pin low if/rf/ref", {if_en, rf_en, ref_en}, 0);
        cyc(); cyc(); settle_look();
        chk("R1 no tune while pin low", tune_active, 0);
        auto_on = 0; if_pwr_bit = 0; rf_pwr_bit = 0;

        // R3: force-on with both bits clear
        cyc(); hw_run = 1; auto_on = 1; settle_look();
        chk("R3 auto forces both", {if_en, rf_en}, 2'b11);
        cyc(); settle_look();
        chk("R5 tune after power-up", tune_active, 1);
        auto_on = 0; cyc(); cyc();

        // R6/R7: IF alone, exact window edges
        if_pwr_bit = 1; settle_look();
        chk("R2 IF bit alone", {if_en, rf_en}, 2'b10);
        cyc(); settle_look();
        chk("R5 IF tune start", tune_active, 1);
        halves(12); settle_look();
        chk("R6 still tuning after 12", tune_active, 1);
        halves(1); settle_look();
        chk("R6 tune ends after 13", tune_active, 0);
        halves(42); settle_look();
        chk("R7 not ready after 55", ready_if, 0);
        halves(1); settle_look();
        chk("R7 ready after 56", ready_if, 1);

        // R8: RF retune during tune restarts count
        aux_sel = 2'b11; rf_pwr_bit = 1; cyc();
        halves(10);
        n_wr_rf_b = 1; half_tick = 1; cyc(); n_wr_rf_b = 0; half_tick = 0;
        halves(12); settle_look();
        chk("R8 restart keeps tuning", tune_active, 1);
        chk("R9 aux shows tune", aux_out, 1);
        chk("R11 sel to B", rf_sel, 1);
        halves(1); settle_look();
        chk("R8 restarted window ends", tune_active, 0);
        near_lim_rf = 1; settle_look();
        chk("R9 near limit raises aux", aux_out, 1);
        for (int k = 0; k < 3; k++) begin
            aux_sel = 2'(k); settle_look();
            chk("R10 other codes low", aux_out, 0);
            cyc();
        end
        near_lim_rf = 0; aux_sel = 2'b11;

        // R11: write while RF off moves select but does not tune
        rf_pwr_bit = 0; halves(60);
        n_wr_rf_a = 1; cyc(); n_wr_rf_a = 0; settle_look();
        chk("R11 sel to A while off", rf_sel, 0);
        chk("R11 no tune from write while off", tune_active, 0);
        n_wr_rf_a = 1; n_wr_rf_b = 1; cyc(); n_wr_rf_a = 0; n_wr_rf_b = 0; settle_look();
        chk("R11 B wins tie", rf_sel, 1);

        // R7: disabling clears ready
        if_pwr_bit = 0; cyc(); settle_look();
        chk("R7 ready cleared on off", ready_if, 0);

        // Random phase, model compared each cycle
        for (int i = 0; i < 6000; i++) begin
            hw_run      = ($urandom % 24) != 0;
            if ($urandom % 40 == 0) auto_on = ~auto_on;
            if ($urandom % 30 == 0) if_pwr_bit = ~if_pwr_bit;
            if ($urandom % 30 == 0) rf_pwr_bit = ~rf_pwr_bit;
            if ($urandom % 50 == 0) aux_sel = 2'($urandom);
            n_wr_if     = ($urandom % 70) == 0;
            n_wr_rf_a   = ($urandom % 90) == 0;
            n_wr_rf_b   = ($urandom % 90) == 0;
            half_tick   = ($urandom % 2) == 0;
            near_lim_if = ($urandom % 12) == 0;
            near_lim_rf = ($urandom % 12) == 0;
            cyc();
        end
        finish_run();
    end
endmodule